// File: doc/BRIEF.md
# Slave-Mode Frame-Clock Alignment Monitor

This block watches the frame clock of an I2S or TDM audio link on which the far end drives both the bit clock and the frame clock. It runs on the incoming bit clock. It finds the frame-clock transition that marks a frame, then counts a fixed number of bit clocks to land on a slot boundary. From there it tracks the slot position bit by bit. In each slot it gathers the frame-clock samples into one word of slot-width bits and compares that word, under a width mask, with the pattern the current format calls for.

The data path uses the outputs to frame its shift registers. These are the slot counter, a frame-start strobe, a lock indication and a sync-error flag that tells it to restart. Two static selects choose the format (two-channel I2S or multi-slot TDM) and the slot width (16 or 32 bits).

Top module: `frame_sync_monitor`

## Requirements
- R1: While reset is applied, and after it until alignment, `locked`, `sync_err` and `frame_start` are 0 and `slot_idx` is 0.
- R2: The search first needs one bit-clock sample at the idle level. In I2S mode (`fmt_tdm`=0) that level is high; in TDM mode (`fmt_tdm`=1) it is low. The edge sample F is the first later sample at the other level. `locked` stays 0 until alignment.
- R3: Edge sample F is followed by the first aligned boundary at sample F + (C×W − W + 1), where C is the slot count and W the slot width. This is 33 for 32-bit two-channel operation and 225 for eight-slot 32-bit TDM. The boundary is bit 0 of slot C−1, and `locked` is 1 for that bit and after it.
- R4: C is 2 when `fmt_tdm`=0 and 8 when `fmt_tdm`=1. W is 16 when `wide_sel`=0 and 32 when `wide_sel`=1. While locked, `slot_idx` gives the slot of the current bit; it advances every W bits and wraps from C−1 to 0.
- R5: `frame_start` is 1 only during bit 0 of slot 0 while locked.
- R6: The slot word holds the W frame-clock samples of a slot, first sample most significant. In I2S mode, slot 0 must read all zeros with a one in the least significant bit, and slot 1 must read all ones with a zero in the least significant bit.
- R7: In TDM mode the word of slot C−1 must be a single one in the least significant bit, and the word of every other slot must be zero.
- R8: At 16-bit width only the 16 samples of the slot are compared; older samples left in the 32-bit word are masked out.
- R9: A mismatch is judged at the last bit of the slot. After that bit, `sync_err` is 1, `locked` is 0, and the search of R2 starts again.
- R10: `sync_err` stays 1 until the monitor has aligned again, and it clears in the same bit as `locked` returns.
- R11: A change of `fmt_tdm` or `wide_sel` while running drops lock on the next bit and restarts the search without setting `sync_err`.
- R12: Asserting `rst_n` low clears the outputs at once, without a bit-clock edge. The release is synchronised to the bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the external device; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| lrclk | input | 1 | Frame clock from the external device |
| fmt_tdm | input | 1 | Format select: 0 two-channel I2S, 1 multi-slot TDM |
| wide_sel | input | 1 | Slot width select: 0 for 16 bits, 1 for 32 bits |
| locked | output | 1 | Slot position is aligned and being tracked |
| slot_idx | output | $clog2(TDM_CH) | Slot of the current bit while locked, else 0 |
| frame_start | output | 1 | High during bit 0 of slot 0 while locked |
| sync_err | output | 1 | Frame-clock word mismatch seen; held until realigned |

## Verification
The assertions take it that the frame clock and both selects change only between rising bit-clock edges. They also take it that the selects stay constant while locked, except for a deliberate change, which must only ever force a resync. The stimulus meets this: it drives every input on the falling edge, holds the frame clock at its idle level through reset, and switches a select only in the one scenario that checks resynchronisation. The frame-clock corruptions are single flipped samples placed well after lock. The search that follows each error therefore sees a clean waveform.

// File: rtl/fsmon_pkg.sv
package fsmon_pkg;

  // Alignment states of the monitor
  typedef enum logic [1:0] {
    ST_SEEK  = 2'd0,  // wait for the idle frame-clock level
    ST_ARM   = 2'd1,  // wait for the frame-marking transition
    ST_COUNT = 2'd2,  // count the fixed offset to the first boundary
    ST_TRACK = 2'd3   // follow slot position and check each slot word
  } fsmon_state_t;

endpackage

// File: rtl/fsmon_rst_sync.sv
module fsmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fsmon_geom.sv
module fsmon_geom #(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int PAIR_CH  = 2,
  parameter int TDM_CH   = 8,
  parameter int BIT_CW   = 5,
  parameter int SLOT_CW  = 3,
  parameter int CNT_W    = 9
) (
  input  logic               fmt_tdm,
  input  logic               wide_sel,
  output logic [BIT_CW-1:0]  slot_last_bit,
  output logic [SLOT_CW-1:0] last_slot,
  output logic [CNT_W-1:0]   align_offset,
  output logic               edge_level
);

  // Offset from the edge sample to the first boundary: C*W - W + 1
  localparam int OFF_PN = PAIR_CH * NARROW_W - NARROW_W + 1;
  localparam int OFF_PW = PAIR_CH * WIDE_W   - WIDE_W   + 1;
  localparam int OFF_TN = TDM_CH  * NARROW_W - NARROW_W + 1;
  localparam int OFF_TW = TDM_CH  * WIDE_W   - WIDE_W   + 1;

  always_comb begin
    slot_last_bit = wide_sel ? BIT_CW'(WIDE_W - 1) : BIT_CW'(NARROW_W - 1);
    last_slot     = fmt_tdm ? SLOT_CW'(TDM_CH - 1) : SLOT_CW'(PAIR_CH - 1);
    unique case ({fmt_tdm, wide_sel})
      2'b00:   align_offset = CNT_W'(OFF_PN);
      2'b01:   align_offset = CNT_W'(OFF_PW);
      2'b10:   align_offset = CNT_W'(OFF_TN);
      default: align_offset = CNT_W'(OFF_TW);
    endcase
    // I2S marks a frame by the frame clock going low, TDM by its high pulse
    edge_level = fmt_tdm;
  end

endmodule

// File: rtl/fsmon_pattern.sv
module fsmon_pattern #(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int SLOT_CW  = 3
) (
  input  logic               fmt_tdm,
  input  logic               wide_sel,
  input  logic [SLOT_CW-1:0] slot_idx,
  input  logic [SLOT_CW-1:0] last_slot,
  input  logic [WIDE_W-1:0]  word_full,
  output logic               mismatch
);

  logic [WIDE_W-1:0] valid_mask;
  logic [WIDE_W-1:0] expect_w;

  // Positions beyond the narrow width hold older samples at 16 bits
  generate
    for (genvar i = 0; i < WIDE_W; i++) begin : g_mask
      if (i < NARROW_W) begin : g_low
        assign valid_mask[i] = 1'b1;
      end else begin : g_high
        assign valid_mask[i] = wide_sel;
      end
    end
  endgenerate

  always_comb begin
    expect_w = '0;
    if (fmt_tdm) begin
      expect_w[0] = (slot_idx == last_slot);
    end else if (slot_idx == '0) begin
      expect_w[0] = 1'b1;
    end else begin
      expect_w    = valid_mask;
      expect_w[0] = 1'b0;
    end
  end

  assign mismatch = |((word_full ^ expect_w) & valid_mask);

endmodule

// File: rtl/fsmon_align.sv
module fsmon_align
  import fsmon_pkg::*;
#(
  parameter int WIDE_W  = 32,
  parameter int BIT_CW  = 5,
  parameter int SLOT_CW = 3,
  parameter int CNT_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lrclk,
  input  logic               fmt_tdm,
  input  logic               wide_sel,
  input  logic [BIT_CW-1:0]  slot_last_bit,
  input  logic [SLOT_CW-1:0] last_slot,
  input  logic [CNT_W-1:0]   align_offset,
  input  logic               edge_level,
  input  logic               mismatch,
  output logic [WIDE_W-1:0]  word_full,
  output logic [SLOT_CW-1:0] slot_idx,
  output logic               locked,
  output logic               frame_start,
  output logic               sync_err
);

  fsmon_state_t       st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SLOT_CW-1:0] slot_q, slot_d;
  logic [BIT_CW-1:0]  bit_q, bit_d;
  logic               err_q, err_d;
  logic [1:0]         cfg_q;
  logic               cfg_chg;
  logic [WIDE_W-2:0]  word_q;
  logic               word_en;

  assign cfg_chg   = ({fmt_tdm, wide_sel} != cfg_q);
  assign word_full = {word_q, lrclk};
  assign word_en   = (st_q == ST_TRACK);

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    bit_d  = bit_q;
    err_d  = err_q;
    if (cfg_chg) begin
      st_d   = ST_SEEK;
      slot_d = '0;
      bit_d  = '0;
    end else begin
      unique case (st_q)
        ST_SEEK: begin
          if (lrclk != edge_level) st_d = ST_ARM;
        end
        ST_ARM: begin
          if (lrclk == edge_level) begin
            st_d  = ST_COUNT;
            cnt_d = align_offset - CNT_W'(1);
          end
        end
        ST_COUNT: begin
          if (cnt_q == CNT_W'(1)) begin
            st_d   = ST_TRACK;
            slot_d = last_slot;
            bit_d  = '0;
            err_d  = 1'b0;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        default: begin
          if (bit_q == slot_last_bit) begin
            bit_d = '0;
            if (mismatch) begin
              st_d   = ST_SEEK;
              err_d  = 1'b1;
              slot_d = '0;
            end else if (slot_q == last_slot) begin
              slot_d = '0;
            end else begin
              slot_d = slot_q + SLOT_CW'(1);
            end
          end else begin
            bit_d = bit_q + BIT_CW'(1);
          end
        end
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SEEK;
      cnt_q  <= '0;
      slot_q <= '0;
      bit_q  <= '0;
      err_q  <= 1'b0;
      cfg_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      bit_q  <= bit_d;
      err_q  <= err_d;
      cfg_q  <= {fmt_tdm, wide_sel};
    end
  end

  // Frame-clock word shifter, enabled only while tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_full[WIDE_W-2:0];
  end

  assign locked      = (st_q == ST_TRACK);
  assign slot_idx    = slot_q;
  assign frame_start = locked && (slot_q == '0) && (bit_q == '0);
  assign sync_err    = err_q;

  // R3: alignment always lands on bit 0 of the last slot
  a_r3_lock_at_last_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (slot_q == last_slot) && (bit_q == '0));

  // R4: slot index never passes the last slot while tracking
  a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (slot_q <= last_slot));

  // R4: bit position steps by one inside a slot
  a_r4_bit_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && (bit_q != '0)) |-> (bit_q == BIT_CW'($past(bit_q) + BIT_CW'(1))));

  // R5: frame-start strobe lasts one bit
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R9: an error appears only as tracking ends
  a_r9_err_ends_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> (!locked && $past(locked)));

  // R10: the error flag clears only together with a new lock
  a_r10_err_clear_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_err) |-> locked);

  // R11: a select change abandons tracking on the next bit
  a_r11_cfg_change_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !locked);

endmodule

// File: rtl/frame_sync_monitor.sv
module frame_sync_monitor #(
  parameter int NARROW_W    = 16,
  parameter int WIDE_W      = 32,
  parameter int TDM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      bclk,
  input  logic                      rst_n,
  input  logic                      lrclk,
  input  logic                      fmt_tdm,
  input  logic                      wide_sel,
  output logic                      locked,
  output logic [$clog2(TDM_CH)-1:0] slot_idx,
  output logic                      frame_start,
  output logic                      sync_err
);

  localparam int PAIR_CH = 2;
  localparam int BIT_CW  = $clog2(WIDE_W);
  localparam int SLOT_CW = $clog2(TDM_CH);
  localparam int CNT_W   = $clog2(TDM_CH * WIDE_W) + 1;

  logic               rst_sync_n;
  logic [BIT_CW-1:0]  slot_last_bit;
  logic [SLOT_CW-1:0] last_slot;
  logic [CNT_W-1:0]   align_offset;
  logic               edge_level;
  logic               mismatch;
  logic [WIDE_W-1:0]  word_full;

  fsmon_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (bclk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsmon_geom #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W),
    .PAIR_CH  (PAIR_CH),
    .TDM_CH   (TDM_CH),
    .BIT_CW   (BIT_CW),
    .SLOT_CW  (SLOT_CW),
    .CNT_W    (CNT_W)
  ) u_geom (
    .fmt_tdm       (fmt_tdm),
    .wide_sel      (wide_sel),
    .slot_last_bit (slot_last_bit),
    .last_slot     (last_slot),
    .align_offset  (align_offset),
    .edge_level    (edge_level)
  );

  fsmon_align #(
    .WIDE_W  (WIDE_W),
    .BIT_CW  (BIT_CW),
    .SLOT_CW (SLOT_CW),
    .CNT_W   (CNT_W)
  ) u_align (
    .clk           (bclk),
    .rst_n         (rst_sync_n),
    .lrclk         (lrclk),
    .fmt_tdm       (fmt_tdm),
    .wide_sel      (wide_sel),
    .slot_last_bit (slot_last_bit),
    .last_slot     (last_slot),
    .align_offset  (align_offset),
    .edge_level    (edge_level),
    .mismatch      (mismatch),
    .word_full     (word_full),
    .slot_idx      (slot_idx),
    .locked        (locked),
    .frame_start   (frame_start),
    .sync_err      (sync_err)
  );

  fsmon_pattern #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W),
    .SLOT_CW  (SLOT_CW)
  ) u_pattern (
    .fmt_tdm   (fmt_tdm),
    .wide_sel  (wide_sel),
    .slot_idx  (slot_idx),
    .last_slot (last_slot),
    .word_full (word_full),
    .mismatch  (mismatch)
  );

endmodule

// File: tb/test_frame_sync_monitor.sv
`timescale 1ns/1ps
module test_frame_sync_monitor;

  localparam int NW  = 16;
  localparam int WW  = 32;
  localparam int TCH = 8;
  localparam int SCW = $clog2(TCH);
  localparam int BIG = 1 << 30;

  logic           bclk = 1'b0;
  logic           rst_n;
  logic           lrclk;
  logic           fmt_tdm;
  logic           wide_sel;
  logic           locked;
  logic [SCW-1:0] slot_idx;
  logic           frame_start;
  logic           sync_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Segment configuration, computed from the requirements
  bit tdm_m, wide_m;
  int w, ch, fr, off, start_pos;
  int flip_k, ke, l1, l2, chg_k;

  frame_sync_monitor #(
    .NARROW_W (NW),
    .WIDE_W   (WW),
    .TDM_CH   (TCH)
  ) i_frame_sync_monitor (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .lrclk       (lrclk),
    .fmt_tdm     (fmt_tdm),
    .wide_sel    (wide_sel),
    .locked      (locked),
    .slot_idx    (slot_idx),
    .frame_start (frame_start),
    .sync_err    (sync_err)
  );

  always #2 bclk = ~bclk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pos_of(int k);
    return (start_pos + k) % fr;
  endfunction

  // Clean frame-clock level for a frame position (R6, R7 waveforms)
  function automatic bit clean_lvl(int p);
    if (tdm_m) return (p == fr - 1);
    return (p >= w - 1) && (p <= 2 * w - 2);
  endfunction

  function automatic bit lvl_at(int k);
    bit v;
    v = clean_lvl(pos_of(k));
    if (k == flip_k) v = ~v;
    return v;
  endfunction

  // R2/R3: idle level, then marking level, then the fixed offset
  function automatic int lock_edge(int from);
    int k;
    bit tgt;
    k   = from;
    tgt = tdm_m;
    while (lvl_at(k) == tgt) k++;
    while (lvl_at(k) != tgt) k++;
    return k + off;
  endfunction

  task automatic run_seg(bit t, bit wd, int mode);
    int n;
    int pflip;
    tdm_m     = t;
    wide_m    = wd;
    w         = wd ? WW : NW;
    ch        = t ? TCH : 2;
    fr        = ch * w;
    off       = ch * w - w + 1;
    start_pos = t ? 0 : w;
    flip_k    = -1;
    ke        = BIG;
    l2        = BIG;
    chg_k     = -1;

    @(negedge bclk);
    #0.5;
    rst_n    = 1'b0;
    fmt_tdm  = t;
    wide_sel = wd;
    lrclk    = ~t;
    #0.5;
    chk("R12", "async locked", locked, 0);
    chk("R12", "async sync_err", sync_err, 0);
    chk("R12", "async frame_start", frame_start, 0);
    repeat (3) @(negedge bclk);
    chk("R1", "reset locked", locked, 0);
    chk("R1", "reset sync_err", sync_err, 0);
    chk("R1", "reset frame_start", frame_start, 0);
    chk("R1", "reset slot_idx", int'(slot_idx), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge bclk);
    chk("R1", "after release locked", locked, 0);

    l1 = lock_edge(0);
    if (t) chk("R3", "offset value", off, wd ? 225 : 113);
    else   chk("R3", "offset value", off, wd ? 33 : 17);

    if (mode == 2) begin
      chg_k = l1 + fr + 5;
      n     = chg_k + 6;
    end else begin
      pflip  = (mode == 0) ? 1 : (t ? 3 * w : w);
      flip_k = l1 + fr;
      while (pos_of(flip_k) != pflip) flip_k++;
      ke = flip_k + (w - 1 - (pos_of(flip_k) % w));
      l2 = lock_edge(ke + 1);
      n  = l2 + 2 * fr;
    end

    for (int k = 0; k < n; k++) begin
      int    p;
      bit    el;
      bit    ee;
      string rq;
      p  = pos_of(k);
      el = ((k >= l1) && (k <= ke)) || (k >= l2);
      ee = (k > ke) && (k < l2);
      if ((chg_k >= 0) && (k > chg_k)) begin
        el = 1'b0;
        ee = 1'b0;
      end
      // lock flag
      if (k == l1)                         rq = "R3";
      else if (k == ke + 1)                rq = "R9";
      else if (k == l2)                    rq = "R10";
      else if ((chg_k >= 0) && (k > chg_k)) rq = "R11";
      else                                 rq = "R2";
      chk(rq, "locked", locked, el);
      // error flag
      if (k == ke + 1)                     rq = "R9";
      else if ((chg_k >= 0) && (k > chg_k)) rq = "R11";
      else if (el)                         rq = t ? "R7" : "R6";
      else                                 rq = "R10";
      chk(rq, "sync_err", sync_err, ee);
      if (!wd && el && (k == l1 + fr)) chk("R8", "narrow slot no error", sync_err, 0);
      if (el) chk("R4", "slot_idx", int'(slot_idx), p / w);
      chk("R5", "frame_start", frame_start, el && (p == 0));
      if (k == chg_k) wide_sel = ~wd;
      lrclk = lvl_at(k);
      @(negedge bclk);
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    lrclk    = 1'b1;
    fmt_tdm  = 1'b0;
    wide_sel = 1'b0;
    for (int t = 0; t < 2; t++)
      for (int wd = 0; wd < 2; wd++)
        for (int m = 0; m < 3; m++)
          run_seg(t[0], wd[0], m);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule